// File: doc/BRIEF.md
# Dual-Mode Sample Output Formatter

This block sits behind a sampling front end that delivers one 8-bit word on every rising edge of the input clock. It formats that stream for the chip's output pins in one of two modes. In paired mode, successive words are steered alternately into two output ports. Both ports update together once every two input clocks. A divide-by-two phase toggle sets the update cadence and is also exported as a half-rate output clock. The port data changes on the falling edge of that clock, so its rising edge falls in the middle of a stable data window. In single mode, every word goes to port 1 at the full input rate. Port 2 holds its value, and the output clock is the inverted input clock.

The mode input is static. It is captured only while the synchronous active-low reset is held, so a change reaches the block through a reset pulse. The same reset forces the phase toggle to a known state. Several instances that share one clock and one reset pulse therefore update their ports on the same edges. A polarity input selects between the true code and its bitwise complement. It is applied to each word at the edge that captures that word.

Top module: `smpd_sample_fmt`

## Requirements
- R1: The mode is taken from `mode_dual_i` at every clock edge where `rst_n_i` is low: 1 selects paired mode and 0 selects single mode. Changes of `mode_dual_i` while `rst_n_i` is high have no effect on the outputs.
- R2: A rising clock edge with `rst_n_i` low clears both ports to zero and clears the phase toggle. In paired mode, `clk_out_o` is therefore low after such an edge.
- R3: In paired mode, the phase toggle inverts at every rising edge of `clk_i` that is not a reset edge, and `clk_out_o` equals the toggle state. The first edge after reset drives `clk_out_o` high.
- R4: In paired mode, the word taken at the first edge after reset is held internally. At the second edge, `port_b_o` receives that held word and `port_a_o` receives the word taken at the second edge. This pattern repeats for every later pair of edges, so port 1 always carries the newer word of a pair.
- R5: In paired mode, both ports keep their values at the edges that raise `clk_out_o`, and they change only at the edges that lower it.
- R6: In single mode, `port_a_o` presents the word taken at each rising edge, starting right after that edge.
- R7: In single mode, `port_b_o` keeps its value. After the reset that entered the mode, that value is zero.
- R8: In single mode, `clk_out_o` is the logical inverse of `clk_i`.
- R9: With `pol_true_i` high when a word is taken, the output code equals the input word, bit 7 being the MSB. With `pol_true_i` low, every output bit is the complement of the matching input bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock; one input word per rising edge |
| rst_n_i | input | 1 | Synchronous active-low reset; clears ports and phase, loads mode |
| mode_dual_i | input | 1 | Mode select captured during reset: 1 paired, 0 single |
| pol_true_i | input | 1 | 1 outputs true code, 0 outputs bitwise complement |
| sample_i | input | 8 | Input sample word, bit 7 is MSB |
| port_a_o | output | 8 | Port 1: newer word of each pair, or every word in single mode |
| port_b_o | output | 8 | Port 2: older word of each pair; held in single mode |
| clk_out_o | output | 1 | Half-rate phase clock in paired mode, inverted input clock in single mode |

## Verification
The assertions run on every cycle. They check that the phase toggle alternates in paired mode and is cleared by reset, and that both ports stay still at the edges that raise the output clock. They also check that port 1 loads the latest coded word whenever it is due, that port 2 never moves in single mode, and that the captured mode cannot change outside reset. Only the bench scenarios can show the pairing order after a reset release, the realignment after a reset that lands mid-pair, and that a select change without reset is ignored. The same holds for the inverted clock seen between edges, and for the full sweep of all 256 codes under both polarities.

// File: rtl/smpd_pkg.sv
package smpd_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_PAIRED = 1'b1
    } smpd_mode_e;

endpackage

// File: rtl/smpd_polarity.sv
module smpd_polarity #(
    parameter int W = 8
) (
    input  logic         pol_true_i,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] code_o
);
    // Each bit is passed straight or complemented under one shared control.
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign code_o[b] = pol_true_i ? sample_i[b] : ~sample_i[b];
    end
endmodule

// File: rtl/smpd_phase_div.sv
module smpd_phase_div
    import smpd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       mode_dual_i,
    output smpd_mode_e mode_o,
    output logic       phase_o
);
    typedef struct packed {
        smpd_mode_e mode;
        logic       phase;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n_i) begin
            // Mode is only sampled while reset is held.
            st_d.mode  = smpd_mode_e'(mode_dual_i);
            st_d.phase = 1'b0;
        end else if (st_q.mode == MODE_PAIRED) begin
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign mode_o  = st_q.mode;
    assign phase_o = st_q.phase;
endmodule

// File: rtl/smpd_lane_regs.sv
module smpd_lane_regs
    import smpd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  smpd_mode_e   mode_i,
    input  logic         phase_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] port_a_o,
    output logic [W-1:0] port_b_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] pa;
        logic [W-1:0] pb;
    } lane_state_t;

    lane_state_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (!rst_n_i) begin
            ln_d = '0;
        end else if (mode_i == MODE_PAIRED) begin
            if (!phase_i) begin
                // First word of a pair waits in the hold stage.
                ln_d.hold = code_i;
            end else begin
                // Second word: both ports load together.
                ln_d.pa = code_i;
                ln_d.pb = ln_q.hold;
            end
        end else begin
            ln_d.pa = code_i;
        end
    end

    always_ff @(posedge clk_i) begin
        ln_q <= ln_d;
    end

    assign port_a_o = ln_q.pa;
    assign port_b_o = ln_q.pb;
endmodule

// File: rtl/smpd_sample_fmt.sv
module smpd_sample_fmt
    import smpd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         mode_dual_i,
    input  logic         pol_true_i,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] port_a_o,
    output logic [W-1:0] port_b_o,
    output logic         clk_out_o
);
    logic [W-1:0] code_w;
    smpd_mode_e   mode_w;
    logic         phase_w;

    smpd_polarity #(.W(W)) pol_i (
        .pol_true_i (pol_true_i),
        .sample_i   (sample_i),
        .code_o     (code_w)
    );

    smpd_phase_div div_i (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .mode_dual_i (mode_dual_i),
        .mode_o      (mode_w),
        .phase_o     (phase_w)
    );

    smpd_lane_regs #(.W(W)) lanes_i (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .mode_i   (mode_w),
        .phase_i  (phase_w),
        .code_i   (code_w),
        .port_a_o (port_a_o),
        .port_b_o (port_b_o)
    );

    assign clk_out_o = (mode_w == MODE_PAIRED) ? phase_w : ~clk_i;
endmodule

// File: rtl/smpd_sample_fmt_chk.sv
module smpd_sample_fmt_chk
    import smpd_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk_i,
    input logic         rst_n_i,
    input logic         pol_true_i,
    input logic [W-1:0] sample_i,
    input logic [W-1:0] port_a_o,
    input logic [W-1:0] port_b_o,
    input smpd_mode_e   mode_w,
    input logic         phase_w
);
    // R1: captured mode never moves outside reset
    a_r1_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        1'b1 |=> $stable(mode_w));

    // R2: a reset edge leaves the phase cleared
    a_r2_phase_cleared: assert property (@(posedge clk_i)
        !rst_n_i |=> !phase_w);

    // R3: phase alternates every edge in paired mode
    a_r3_phase_toggles: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_w == MODE_PAIRED) |=> (phase_w != $past(phase_w)));

    // R5: no port change on the edge that raises the exported clock
    a_r5_ports_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_w == MODE_PAIRED && !phase_w) |=> ($stable(port_a_o) && $stable(port_b_o)));

    // R4, R6, R9: port 1 takes the coded current word when it is due
    a_r6_port_a_loads: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_w == MODE_SINGLE || phase_w)
        |=> (port_a_o == ($past(sample_i) ^ {W{~$past(pol_true_i)}})));

    // R7: port 2 frozen in single mode
    a_r7_port_b_held: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_w == MODE_SINGLE) |=> $stable(port_b_o));
endmodule

bind smpd_sample_fmt smpd_sample_fmt_chk #(.W(W)) chk_i (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .pol_true_i (pol_true_i),
    .sample_i   (sample_i),
    .port_a_o   (port_a_o),
    .port_b_o   (port_b_o),
    .mode_w     (mode_w),
    .phase_w    (phase_w)
);

// File: tb/smpd_sample_fmt_tb.sv
module smpd_sample_fmt_tb_top;
    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;

    logic         clk_i = 1'b0;
    logic         rst_n_i = 1'b0;
    logic         mode_dual_i = 1'b1;
    logic         pol_true_i = 1'b1;
    logic [W-1:0] sample_i = '0;
    logic [W-1:0] port_a_o, port_b_o;
    logic         clk_out_o;

    int n_checks = 0;
    int n_fails  = 0;

    smpd_sample_fmt #(.W(W)) dut_i (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .mode_dual_i (mode_dual_i),
        .pol_true_i  (pol_true_i),
        .sample_i    (sample_i),
        .port_a_o    (port_a_o),
        .port_b_o    (port_b_o),
        .clk_out_o   (clk_out_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] coded(input logic [W-1:0] v, input logic p);
        return p ? v : ~v;
    endfunction

    function automatic logic [W-1:0] word_of(input int i);
        return W'((i * 37 + 11) % 256);
    endfunction

    // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(input logic [W-1:0] v, input logic p);
        sample_i   = v;
        pol_true_i = p;
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic do_reset(input logic md, input int cycles);
        rst_n_i     = 1'b0;
        mode_dual_i = md;
        for (int c = 0; c < cycles; c++) step(8'h5A, 1'b1);
        chk("R2 port_a in reset", port_a_o, 0);
        chk("R2 port_b in reset", port_b_o, 0);
        if (md) chk("R2 clk_out low in reset", clk_out_o, 0);
        rst_n_i = 1'b1;
    endtask

    // Run n pairs in paired mode, starting right after a reset release.
    task automatic run_pairs(input int base, input int n);
        logic [W-1:0] pa, pb, first;
        for (int k = 0; k < n; k++) begin
            pa = port_a_o;
            pb = port_b_o;
            first = coded(word_of(base + 2*k), ((base + k) % 3) != 0);
            step(word_of(base + 2*k), ((base + k) % 3) != 0);
            chk("R3 clk_out high after odd edge", clk_out_o, 1);
            chk("R5 port_a quiet on rising clk_out", port_a_o, pa);
            chk("R5 port_b quiet on rising clk_out", port_b_o, pb);
            step(word_of(base + 2*k + 1), ((base + k + 1) % 3) != 0);
            chk("R3 clk_out low after even edge", clk_out_o, 0);
            chk("R4 R9 port_a newer word",
                port_a_o, coded(word_of(base + 2*k + 1), ((base + k + 1) % 3) != 0));
            chk("R4 R9 port_b older word", port_b_o, first);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk_i);

        // Paired mode: sweep all 256 codes in 128 pairs, mixed polarity.
        do_reset(1'b1, 3);
        run_pairs(0, 128);

        // R1: select dropped without reset is ignored.
        mode_dual_i = 1'b0;
        run_pairs(300, 8);

        // R2/R4: reset landing mid-pair realigns the phase.
        step(8'hC3, 1'b1);
        chk("R3 clk_out high mid-pair", clk_out_o, 1);
        do_reset(1'b1, 1);
        run_pairs(500, 4);

        // Single mode via reset pulse.
        do_reset(1'b0, 2);
        for (int i = 0; i < 256; i++) begin
            step(word_of(i), (i % 5) != 0);
            chk("R6 R9 port_a each word", port_a_o, coded(word_of(i), (i % 5) != 0));
            chk("R7 port_b held", port_b_o, 0);
            chk("R8 clk_out high while clk low", clk_out_o, 1);
        end
        @(posedge clk_i);
        #1;
        chk("R8 clk_out low while clk high", clk_out_o, 0);
        @(negedge clk_i);

        // R1: select raised without reset is ignored in single mode.
        mode_dual_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step(word_of(700 + i), 1'b0);
            chk("R1 still single port_a", port_a_o, coded(word_of(700 + i), 1'b0));
            chk("R1 still single port_b", port_b_o, 0);
            chk("R1 still inverted clk", clk_out_o, 1);
        end

        // Extremes of the code under both polarities.
        do_reset(1'b0, 1);
        step(8'hFF, 1'b1);
        chk("R9 full scale true", port_a_o, 8'hFF);
        step(8'h00, 1'b1);
        chk("R9 zero true", port_a_o, 8'h00);
        step(8'hFF, 1'b0);
        chk("R9 full scale inverted", port_a_o, 8'h00);
        step(8'h80, 1'b0);
        chk("R9 msb inverted", port_a_o, 8'h7F);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule